// File: doc/BRIEF.md
# Radio Data Group Status and Interrupt Reporter

This block sits between a radio data decoder and the host-facing status logic of a broadcast receiver. The decoder emits one pulse for each group it assembles. With that pulse come three things: a flag saying whether the group passed its checks, the decoder's current synchronisation state, and a raw bit-error count for each of the four blocks in the group. From these inputs the block produces a sticky ready flag, a synchronisation status bit, a 2-bit error level for each block, and an active-low interrupt pin. The ready flag and the interrupt pulse are timed against a one-millisecond tick.

The block has two reporting modes:

- **Standard mode** accepts a group only when the decoder marks it valid. In this mode the synchronisation bit and all error fields stay at zero.
- **Verbose mode** accepts any group that arrives while the decoder is synchronised. It also reports the synchronisation state and the quantised error level of each block.

A master enable silences the whole block. The interrupt pin is driven only when the interrupt enable is set and the pin function select chooses the radio-data function.

Top module: `rds_status_irq`

## Requirements
- R1: In standard mode (`verbose_mode`=0), the ready flag and the interrupt pulse start only for a group with `grp_valid`=1. A group with `grp_valid`=0 produces neither.
- R2: A qualifying group raises `ready` on the next clock. `ready` then stays high until the (READY_MS+1)-th `ms_tick` seen after that group, so it is held for at least READY_MS ms.
- R3: When `irq_en`=1 and `pin_sel`=2'b10, a qualifying group drives `irq_n` low from the next clock. `irq_n` stays low until the (PULSE_MS+1)-th `ms_tick` after that group.
- R4: If `irq_en`=0 or `pin_sel` is anything other than 2'b10, `irq_n` is held at 1.
- R5: A qualifying group that arrives while the flag or the pulse is still active restarts the hold count of both.
- R6: In standard mode, `sync_stat` reads 0 and every field of `blk_lvl` reads 0 from the next clock on.
- R7: In verbose mode, `sync_stat` equals the `dec_sync` value of the previous clock. A group qualifies only if `dec_sync`=1 in its cycle; `grp_valid` is ignored.
- R8: Block i's error count is taken from `blk_errs[4i+3:4i]`. Its level is written to `blk_lvl[2i+1:2i]` using these bands: 0 errors gives 00, 1–2 gives 01, 3–5 gives 10, and 6 or more gives 11 (uncorrectable).
- R9: In verbose mode, all four error levels are captured in the same clock as the ready flag is set. They keep their values until the next qualifying group.
- R10: While `rds_en`=0, no group qualifies. On the next clock `ready`=0, `sync_stat`=0, `blk_lvl`=0 and `irq_n`=1, and any running hold is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| rds_en | input | 1 | Master enable for radio data reporting |
| verbose_mode | input | 1 | 0 = standard mode, 1 = verbose mode |
| irq_en | input | 1 | Interrupt enable |
| pin_sel | input | 2 | Pin function select; 2'b10 routes the group interrupt to the pin |
| grp_rcvd | input | 1 | One-cycle pulse: decoder finished a group |
| grp_valid | input | 1 | Group passed the decoder's checks (sampled with `grp_rcvd`) |
| dec_sync | input | 1 | Decoder synchronisation state |
| blk_errs | input | 16 | Four 4-bit bit-error counts, block 0 in bits [3:0] |
| ready | output | 1 | Sticky group-ready flag |
| sync_stat | output | 1 | Reported synchronisation status |
| blk_lvl | output | 8 | Four 2-bit error levels, block 0 in bits [1:0] |
| irq_n | output | 1 | Active-low interrupt pin |

## Verification
If a hold counter is corrupted, the fault shows up at `ready` or `irq_n` as a falling edge on the wrong millisecond tick. That is visible within about READY_MS ticks of the last group. If the accept rule is decoded wrongly, a spurious or missing rise appears on the clock right after the `grp_rcvd` pulse. A fault in the capture path or the band quantiser appears on `blk_lvl` in that same clock. A missing hold appears on the next group that fails to qualify, when the fields change even though they should be frozen.

// File: rtl/rds_stat_pkg.sv
package rds_stat_pkg;

    // Quantised per-block error level
    typedef enum logic [1:0] {
        LVL_CLEAN = 2'b00,
        LVL_FEW   = 2'b01,
        LVL_MANY  = 2'b10,
        LVL_BAD   = 2'b11
    } err_lvl_e;

    // Pin function code that routes the group interrupt to the pin
    localparam logic [1:0] PIN_FN_GROUP = 2'b10;

endpackage

// File: rtl/rds_err_band.sv
module rds_err_band
    import rds_stat_pkg::*;
#(
    parameter int ERR_W = 4
) (
    input  logic [ERR_W-1:0] errs,
    output logic [1:0]       lvl
);

    err_lvl_e band;

    always_comb begin
        if (errs == '0)
            band = LVL_CLEAN;
        else if (errs <= ERR_W'(2))
            band = LVL_FEW;
        else if (errs <= ERR_W'(5))
            band = LVL_MANY;
        else
            band = LVL_BAD;
    end

    assign lvl = band;

endmodule

// File: rtl/rds_hold_timer.sv
module rds_hold_timer #(
    parameter int HOLD_MS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic load,
    input  logic tick,
    output logic active
);

    localparam int             CW     = $clog2(HOLD_MS + 2);
    localparam logic [CW-1:0]  RELOAD = CW'(HOLD_MS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (load)
            cnt_d = RELOAD;
        else if (tick && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/rds_status_irq.sv
module rds_status_irq
    import rds_stat_pkg::*;
#(
    parameter int READY_MS = 40,
    parameter int PULSE_MS = 5,
    parameter int NBLK     = 4,
    parameter int ERR_W    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ms_tick,
    input  logic                  rds_en,
    input  logic                  verbose_mode,
    input  logic                  irq_en,
    input  logic [1:0]            pin_sel,
    input  logic                  grp_rcvd,
    input  logic                  grp_valid,
    input  logic                  dec_sync,
    input  logic [NBLK*ERR_W-1:0] blk_errs,
    output logic                  ready,
    output logic                  sync_stat,
    output logic [2*NBLK-1:0]     blk_lvl,
    output logic                  irq_n
);

    localparam int LVL_W = 2 * NBLK;

    typedef struct packed {
        logic             sync;
        logic [LVL_W-1:0] lvl;
    } stat_t;

    stat_t st_d, st_q;

    logic             accept;
    logic             pin_routed;
    logic             pulse_active;
    logic [LVL_W-1:0] lvl_now;

    // Quantise each block's error count
    for (genvar b = 0; b < NBLK; b++) begin : g_band
        rds_err_band #(.ERR_W(ERR_W)) u_band (
            .errs (blk_errs[b*ERR_W +: ERR_W]),
            .lvl  (lvl_now[2*b +: 2])
        );
    end

    // Group acceptance rule depends on the mode
    always_comb begin
        accept = 1'b0;
        if (rds_en && grp_rcvd)
            accept = verbose_mode ? dec_sync : grp_valid;
    end

    assign pin_routed = irq_en && (pin_sel == PIN_FN_GROUP);

    rds_hold_timer #(.HOLD_MS(READY_MS)) u_ready_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!rds_en),
        .load   (accept),
        .tick   (ms_tick),
        .active (ready)
    );

    rds_hold_timer #(.HOLD_MS(PULSE_MS)) u_pulse_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (!rds_en),
        .load   (accept && pin_routed),
        .tick   (ms_tick),
        .active (pulse_active)
    );

    always_comb begin
        st_d = st_q;
        if (!rds_en || !verbose_mode) begin
            st_d.sync = 1'b0;
            st_d.lvl  = '0;
        end else begin
            st_d.sync = dec_sync;
            if (accept)
                st_d.lvl = lvl_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign sync_stat = st_q.sync;
    assign blk_lvl   = st_q.lvl;
    assign irq_n     = !(pulse_active && pin_routed);

endmodule

// File: rtl/rds_status_irq_chk.sv
module rds_status_irq_chk #(
    parameter int NBLK  = 4,
    parameter int ERR_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rds_en,
    input logic                  verbose_mode,
    input logic                  irq_en,
    input logic [1:0]            pin_sel,
    input logic                  grp_rcvd,
    input logic                  grp_valid,
    input logic                  dec_sync,
    input logic                  ready,
    input logic                  sync_stat,
    input logic [2*NBLK-1:0]     blk_lvl,
    input logic                  irq_n
);

    // R1
    invalid_group_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !verbose_mode && grp_rcvd && !grp_valid) |=> !ready);

    // R2
    ready_needs_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(grp_rcvd && rds_en));

    // R4
    pin_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || pin_sel != 2'b10) |-> irq_n);

    // R6
    std_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !verbose_mode |=> (!sync_stat && blk_lvl == '0));

    // R7
    sync_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rds_en && verbose_mode) |=> (sync_stat == $past(dec_sync)));

    // R9
    lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rds_en && verbose_mode && !(grp_rcvd && dec_sync)) |=> $stable(blk_lvl));

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rds_en |=> (!ready && !sync_stat && irq_n && blk_lvl == '0));

endmodule

bind rds_status_irq rds_status_irq_chk #(.NBLK(NBLK), .ERR_W(ERR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rds_en       (rds_en),
    .verbose_mode (verbose_mode),
    .irq_en       (irq_en),
    .pin_sel      (pin_sel),
    .grp_rcvd     (grp_rcvd),
    .grp_valid    (grp_valid),
    .dec_sync     (dec_sync),
    .ready        (ready),
    .sync_stat    (sync_stat),
    .blk_lvl      (blk_lvl),
    .irq_n        (irq_n)
);

// File: tb/tb_rds_status_irq.sv
module tb_rds_status_irq;

    localparam int CLK_PERIOD = 10;
    localparam int READY_MS   = 40;
    localparam int PULSE_MS   = 5;
    localparam int TICK_DIV   = 3;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        rds_en = 1'b0;
    logic        verbose_mode = 1'b0;
    logic        irq_en = 1'b0;
    logic [1:0]  pin_sel = 2'b00;
    logic        grp_rcvd = 1'b0;
    logic        grp_valid = 1'b0;
    logic        dec_sync = 1'b0;
    logic [15:0] blk_errs = '0;
    logic        ready, sync_stat, irq_n;
    logic [7:0]  blk_lvl;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    started = 0;
    string phase = "reset R10";

    // reference model state
    int m_rdy = 0;
    int m_pls = 0;
    int m_sync = 0;
    int m_lvl[4] = '{0, 0, 0, 0};

    rds_status_irq #(.READY_MS(READY_MS), .PULSE_MS(PULSE_MS)) dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rds_en(rds_en),
        .verbose_mode(verbose_mode), .irq_en(irq_en), .pin_sel(pin_sel),
        .grp_rcvd(grp_rcvd), .grp_valid(grp_valid), .dec_sync(dec_sync),
        .blk_errs(blk_errs), .ready(ready), .sync_stat(sync_stat),
        .blk_lvl(blk_lvl), .irq_n(irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int band(input int e);
        if (e == 0) return 0;
        if (e <= 2) return 1;
        if (e <= 5) return 2;
        return 3;
    endfunction

    // millisecond tick generator
    int tdiv = 0;
    always @(posedge clk) begin
        #2;
        tdiv = (tdiv + 1) % TICK_DIV;
        ms_tick <= (tdiv == 0);
    end

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        bit acc;
        started = 1;
        cycles++;
        if (!rst_n) begin
            m_rdy = 0; m_pls = 0; m_sync = 0;
            for (int i = 0; i < 4; i++) m_lvl[i] = 0;
        end else if (!rds_en) begin
            m_rdy = 0; m_pls = 0; m_sync = 0;
            for (int i = 0; i < 4; i++) m_lvl[i] = 0;
        end else begin
            acc = grp_rcvd && (verbose_mode ? dec_sync : grp_valid);
            if (acc) m_rdy = READY_MS + 1;
            else if (ms_tick && m_rdy > 0) m_rdy--;
            if (acc && irq_en && pin_sel == 2'b10) m_pls = PULSE_MS + 1;
            else if (ms_tick && m_pls > 0) m_pls--;
            if (!verbose_mode) begin
                m_sync = 0;
                for (int i = 0; i < 4; i++) m_lvl[i] = 0;
            end else begin
                m_sync = dec_sync;
                if (acc)
                    for (int i = 0; i < 4; i++) m_lvl[i] = band(int'(blk_errs[4*i +: 4]));
            end
        end
    end

    // comparison away from the active edge
    always @(negedge clk) begin
        if (started) begin
            logic       e_rdy, e_sync, e_irq;
            logic [7:0] e_lvl;
            e_rdy  = (m_rdy > 0);
            e_sync = (m_sync != 0);
            e_irq  = !((m_pls > 0) && irq_en && pin_sel == 2'b10);
            for (int i = 0; i < 4; i++) e_lvl[2*i +: 2] = 2'(m_lvl[i]);
            n_vec++;
            if (ready !== e_rdy) begin
                n_bad++;
                $display("FAIL %s R2 ready act=%0b exp=%0b t=%0t", phase, ready, e_rdy, $time);
            end
            if (irq_n !== e_irq) begin
                n_bad++;
                $display("FAIL %s R3 irq_n act=%0b exp=%0b t=%0t", phase, irq_n, e_irq, $time);
            end
            if (sync_stat !== e_sync) begin
                n_bad++;
                $display("FAIL %s R7 sync_stat act=%0b exp=%0b t=%0t", phase, sync_stat, e_sync, $time);
            end
            if (blk_lvl !== e_lvl) begin
                n_bad++;
                $display("FAIL %s R8 blk_lvl act=%h exp=%h t=%0t", phase, blk_lvl, e_lvl, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic group(input bit valid, input logic [15:0] errs);
        grp_rcvd = 1'b1; grp_valid = valid; blk_errs = errs;
        step(1);
        grp_rcvd = 1'b0; grp_valid = 1'b0;
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        rds_en = 1'b1; irq_en = 1'b1; pin_sel = 2'b10;
        step(2);

        phase = "R1 invalid group std mode R6";
        group(1'b0, 16'hFFFF);
        step(20);
        phase = "R1 valid group, R2 hold, R3 pulse";
        group(1'b1, 16'h6310);
        step(150);

        phase = "R5 restart of both holds";
        group(1'b1, 16'h0000);
        step(10);
        group(1'b1, 16'h0000);
        step(60);
        group(1'b1, 16'h0000);
        step(150);

        phase = "R4 pin function not selected";
        pin_sel = 2'b01;
        group(1'b1, 16'h0000);
        step(30);
        pin_sel = 2'b10; irq_en = 1'b0;
        group(1'b1, 16'h0000);
        step(10);
        phase = "R4 interrupt enable rises mid hold";
        irq_en = 1'b1;
        step(150);

        phase = "R7 verbose unsynced group ignored";
        verbose_mode = 1'b1; dec_sync = 1'b0;
        group(1'b1, 16'h3333);
        step(20);
        phase = "R7 sync follows decoder";
        dec_sync = 1'b1;
        step(5);
        phase = "R8 bands 0,1,3,6";
        group(1'b0, 16'h6310);
        step(8);
        phase = "R8 bands 2,5,15,0";
        group(1'b0, 16'h0F52);
        step(8);
        phase = "R8 bands 4,7,1,2";
        group(1'b1, 16'h2174);
        step(8);
        phase = "R9 levels held on unsynced group";
        dec_sync = 1'b0;
        group(1'b1, 16'hFFFF);
        step(3);
        dec_sync = 1'b1;
        step(150);

        phase = "R6 return to standard clears fields";
        verbose_mode = 1'b0;
        step(5);
        verbose_mode = 1'b1;
        group(1'b0, 16'h9999);
        step(10);

        phase = "R10 disable cancels holds";
        rds_en = 1'b0;
        step(3);
        group(1'b1, 16'h1111);
        step(10);
        rds_en = 1'b1;
        step(60);
        phase = "R10 re-enabled";
        group(1'b0, 16'h0000);
        step(150);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        wait (cycles >= WATCHDOG);
        n_bad++;
        $display("FAIL watchdog R2 act=%0d cycles exp<%0d", cycles, WATCHDOG);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule